// File: doc/BRIEF.md
# SD Command Register Unit

This unit is the software-facing front of an SD/MMC host. It exposes a small byte-addressed register space. Software fills in a command index, a 32-bit argument, a response kind, and the length and count of data blocks. It then writes the control byte with the start bit set. The unit presents the command on a card-side request/acknowledge port and waits for the card to return a 16-byte response or go quiet. The response bytes land in a buffer that software reads back, and the unit raises a completion flag or a timeout flag.

Serialisation, CRC and the CMD-line waveform belong to the card-side logic behind the port. A response with a trailing busy phase is tracked through a separate busy input from that logic. Data commands carry a command-type tag in the upper nibble of the control byte. The response buffer is rotated by one byte: the last byte of the response sits at the lowest buffer offset.

Top module: `sdc_cmd_regs`

## Requirements
- R1: After reset the control byte, both status bytes and all 16 response bytes read 0, card_req_o is low, and the timeout register reads its reset default (0x00FF by default).
- R2: Each register reads back what was written: index at 0x01, response kind at 0x02, argument at 0x04..0x07 (least significant byte at 0x04), block length at 0x0C/0x0D, block count at 0x0E/0x0F, and timeout at 0x2C/0x2D (low byte first). card_arg_o, card_blk_cnt_o and card_blk_len_o (block-length bits [10:0], which hold the size minus one) follow these registers. Block-length bits [15:11] are flag bits that are stored and read back but not driven to the card.
- R3: In the control byte, bit 0 is start, bit 2 is write direction and bits [7:4] are the command type (0 none, 1 single write, 2 single read, 3 multi write, 4 multi read, 7 stop). Type and direction drive card_cmd_type_o and card_write_o. Bit 0 reads 1 from the start write until the card acknowledges the request, then reads 0. card_req_o stays high until card_ack_i.
- R4: While a command is in flight, writes to the control byte, index, response kind and argument are dropped, so a second start launches nothing.
- R5: Response byte n (card_rsp_i[8n+7:8n], n = 4*word + byte) is stored at offset 0x10 + ((n+1) mod 16), so byte 15 reads at 0x10.
- R6: A completed command sets status byte 0x29 bit 1. Status byte 0x2A bit 4 reads 1 while a command is in flight.
- R7: If no response arrives within the number of waiting cycles held in the timeout register, status 0x29 bit 2 is set instead of bit 1, and the response buffer is left unchanged. A response in the last allowed cycle still counts as a response.
- R8: With response kind 0 the command completes as soon as it is acknowledged, and the buffer is left unchanged.
- R9: With response kind 9, status 0x2A bit 5 reads 1 from response capture while card_busy_i is high, and the done flag is raised only after the busy phase ends.
- R10: Writing control bit 3 while idle clears all 16 response bytes at that edge. Bit 3 always reads 0.
- R11: Writing 1 to bit 1 or bit 2 of 0x29 clears that flag. Writing 0 to a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| card_req_o | output | 1 | Command request to card side |
| card_ack_i | input | 1 | Card side accepted the command |
| card_cmd_idx_o | output | 8 | Command index |
| card_arg_o | output | 32 | Command argument |
| card_rsp_type_o | output | 8 | Response kind code |
| card_cmd_type_o | output | 4 | Command type tag |
| card_write_o | output | 1 | Data direction is write |
| card_blk_len_o | output | BLK_LEN_W | Block size minus one |
| card_blk_cnt_o | output | 16 | Block count |
| card_rsp_valid_i | input | 1 | Response bytes valid this cycle |
| card_rsp_i | input | 128 | Response bytes, byte n at [8n+7:8n] |
| card_busy_i | input | 1 | Card holds busy after a kind-9 response |

## Verification
The bench goes after the rotated response placement. A design that stores bytes in natural order would read byte 0, not byte 15, at offset 0x10. It also probes the exact timeout boundary: a counter off by one would raise the timeout flag one cycle early or late. A start written while a command is in flight would, in a faulty design, launch a second request or overwrite the latched index and type. The bench also covers a response with a busy phase: a design that flags done at capture would show done while status bit 5 is still set. Finally it checks that a FIFO reset really zeroes the buffer and never reads back as set.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned RSP_BYTES = 16;
    localparam int unsigned RSP_IDX_W = $clog2(RSP_BYTES);
    localparam int unsigned TMO_W     = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_IDX    = 6'h01;
    localparam logic [ADDR_W-1:0] OFS_RKIND  = 6'h02;
    localparam logic [ADDR_W-1:0] OFS_ARG0   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ARG1   = 6'h05;
    localparam logic [ADDR_W-1:0] OFS_ARG2   = 6'h06;
    localparam logic [ADDR_W-1:0] OFS_ARG3   = 6'h07;
    localparam logic [ADDR_W-1:0] OFS_BLEN_L = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_BLEN_H = 6'h0D;
    localparam logic [ADDR_W-1:0] OFS_BCNT_L = 6'h0E;
    localparam logic [ADDR_W-1:0] OFS_BCNT_H = 6'h0F;
    localparam logic [ADDR_W-1:0] OFS_STAT1  = 6'h29;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 6'h2A;
    localparam logic [ADDR_W-1:0] OFS_TMO_L  = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_TMO_H  = 6'h2D;

    localparam int unsigned CTRL_GO_BIT    = 0;
    localparam int unsigned CTRL_WDIR_BIT  = 2;
    localparam int unsigned CTRL_FLUSH_BIT = 3;
    localparam int unsigned ST1_DONE_BIT   = 1;
    localparam int unsigned ST1_TMO_BIT    = 2;

    localparam logic [7:0] RKIND_NONE = 8'd0;
    localparam logic [7:0] RKIND_BUSY = 8'd9;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_WAIT,
        SEQ_HOLD
    } seq_state_e;
endpackage

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
    import sdc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             no_rsp_i,
    input  logic             busy_rsp_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             card_ack_i,
    input  logic             card_rsp_valid_i,
    input  logic             card_busy_i,
    output logic             card_req_o,
    output logic             active_o,
    output logic             pending_o,
    output logic             hold_o,
    output logic             capture_o,
    output logic             done_o,
    output logic             timeout_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [TMO_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        capture_o = 1'b0;
        done_o    = 1'b0;
        timeout_o = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st  = SEQ_ISSUE;
                    seq_d.cnt = '0;
                end
            end
            SEQ_ISSUE: begin
                if (card_ack_i) begin
                    if (no_rsp_i) begin
                        seq_d.st = SEQ_IDLE;
                        done_o   = 1'b1;
                    end else begin
                        seq_d.st  = SEQ_WAIT;
                        seq_d.cnt = '0;
                    end
                end
            end
            SEQ_WAIT: begin
                if (card_rsp_valid_i) begin
                    capture_o = 1'b1;
                    if (busy_rsp_i) begin
                        seq_d.st = SEQ_HOLD;
                    end else begin
                        seq_d.st = SEQ_IDLE;
                        done_o   = 1'b1;
                    end
                end else if (seq_q.cnt >= tmo_limit_i) begin
                    seq_d.st  = SEQ_IDLE;
                    timeout_o = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (!card_busy_i) begin
                    seq_d.st = SEQ_IDLE;
                    done_o   = 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign card_req_o = (seq_q.st == SEQ_ISSUE);
    assign pending_o  = (seq_q.st == SEQ_ISSUE);
    assign active_o   = (seq_q.st != SEQ_IDLE);
    assign hold_o     = (seq_q.st == SEQ_HOLD);
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
    import sdc_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clear_i,
    input  logic                     load_i,
    input  logic [RSP_BYTES*8-1:0]   rsp_i,
    input  logic [RSP_IDX_W-1:0]     rd_idx_i,
    output logic [7:0]               rd_byte_o,
    output logic [RSP_BYTES*8-1:0]   flat_o
);
    typedef struct packed {
        logic [RSP_BYTES-1:0][7:0] slot;
    } store_t;

    store_t store_d, store_q;
    logic [RSP_BYTES-1:0][7:0] placed;

    for (genvar n = 0; n < RSP_BYTES; n++) begin : g_place
        localparam int unsigned SLOT = (n + 1) % RSP_BYTES;
        assign placed[SLOT] = rsp_i[8*n +: 8];
    end

    always_comb begin
        store_d = store_q;
        if (clear_i) begin
            store_d.slot = '0;
        end else if (load_i) begin
            store_d.slot = placed;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_byte_o = store_q.slot[rd_idx_i];
    assign flat_o    = store_q.slot;
endmodule

// File: rtl/sdc_cmd_regs.sv
module sdc_cmd_regs
    import sdc_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_RESET = 16'h00FF,
    parameter int unsigned      BLK_LEN_W = 11
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   reg_wr_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [7:0]             reg_wdata_i,
    output logic [7:0]             reg_rdata_o,
    output logic                   card_req_o,
    input  logic                   card_ack_i,
    output logic [7:0]             card_cmd_idx_o,
    output logic [31:0]            card_arg_o,
    output logic [7:0]             card_rsp_type_o,
    output logic [3:0]             card_cmd_type_o,
    output logic                   card_write_o,
    output logic [BLK_LEN_W-1:0]   card_blk_len_o,
    output logic [15:0]            card_blk_cnt_o,
    input  logic                   card_rsp_valid_i,
    input  logic [RSP_BYTES*8-1:0] card_rsp_i,
    input  logic                   card_busy_i
);
    typedef struct packed {
        logic [7:0]       idx;
        logic [7:0]       rkind;
        logic [31:0]      arg;
        logic [15:0]      blen;
        logic [15:0]      bcnt;
        logic [TMO_W-1:0] tmo;
        logic [3:0]       ctype;
        logic             wdir;
        logic             f_done;
        logic             f_tmo;
    } regs_t;

    regs_t regs_d, regs_q;

    logic seq_active, seq_pending, seq_hold, seq_capture, seq_done, seq_tmo;
    logic start_go, flush_go, ctrl_wr;
    logic [7:0] rsp_byte;
    logic [RSP_BYTES*8-1:0] rsp_flat;
    logic done_flag;

    assign ctrl_wr  = reg_wr_i && (reg_addr_i == OFS_CTRL) && !seq_active;
    assign start_go = ctrl_wr && reg_wdata_i[CTRL_GO_BIT];
    assign flush_go = ctrl_wr && reg_wdata_i[CTRL_FLUSH_BIT];

    always_comb begin
        regs_d = regs_q;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                OFS_CTRL: begin
                    if (!seq_active) begin
                        regs_d.ctype = reg_wdata_i[7:4];
                        regs_d.wdir  = reg_wdata_i[CTRL_WDIR_BIT];
                    end
                end
                OFS_IDX:   if (!seq_active) regs_d.idx   = reg_wdata_i;
                OFS_RKIND: if (!seq_active) regs_d.rkind = reg_wdata_i;
                OFS_ARG0, OFS_ARG1, OFS_ARG2, OFS_ARG3: begin
                    if (!seq_active) regs_d.arg[8*reg_addr_i[1:0] +: 8] = reg_wdata_i;
                end
                OFS_BLEN_L: regs_d.blen[7:0]  = reg_wdata_i;
                OFS_BLEN_H: regs_d.blen[15:8] = reg_wdata_i;
                OFS_BCNT_L: regs_d.bcnt[7:0]  = reg_wdata_i;
                OFS_BCNT_H: regs_d.bcnt[15:8] = reg_wdata_i;
                OFS_TMO_L:  regs_d.tmo[7:0]   = reg_wdata_i;
                OFS_TMO_H:  regs_d.tmo[15:8]  = reg_wdata_i;
                OFS_STAT1: begin
                    if (reg_wdata_i[ST1_DONE_BIT]) regs_d.f_done = 1'b0;
                    if (reg_wdata_i[ST1_TMO_BIT])  regs_d.f_tmo  = 1'b0;
                end
                default: ;
            endcase
        end
        if (seq_done) regs_d.f_done = 1'b1;
        if (seq_tmo)  regs_d.f_tmo  = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q     <= '0;
            regs_q.tmo <= TMO_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    sdc_cmd_seq u_seq (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .start_i          (start_go),
        .no_rsp_i         (regs_q.rkind == RKIND_NONE),
        .busy_rsp_i       (regs_q.rkind == RKIND_BUSY),
        .tmo_limit_i      (regs_q.tmo),
        .card_ack_i       (card_ack_i),
        .card_rsp_valid_i (card_rsp_valid_i),
        .card_busy_i      (card_busy_i),
        .card_req_o       (card_req_o),
        .active_o         (seq_active),
        .pending_o        (seq_pending),
        .hold_o           (seq_hold),
        .capture_o        (seq_capture),
        .done_o           (seq_done),
        .timeout_o        (seq_tmo)
    );

    sdc_rsp_store u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (flush_go),
        .load_i    (seq_capture),
        .rsp_i     (card_rsp_i),
        .rd_idx_i  (reg_addr_i[RSP_IDX_W-1:0]),
        .rd_byte_o (rsp_byte),
        .flat_o    (rsp_flat)
    );

    always_comb begin
        reg_rdata_o = 8'h00;
        if (reg_addr_i[5:4] == 2'b01) begin
            reg_rdata_o = rsp_byte;
        end else begin
            unique case (reg_addr_i)
                OFS_CTRL:   reg_rdata_o = {regs_q.ctype, 1'b0, regs_q.wdir, 1'b0, seq_pending};
                OFS_IDX:    reg_rdata_o = regs_q.idx;
                OFS_RKIND:  reg_rdata_o = regs_q.rkind;
                OFS_ARG0, OFS_ARG1, OFS_ARG2, OFS_ARG3:
                            reg_rdata_o = regs_q.arg[8*reg_addr_i[1:0] +: 8];
                OFS_BLEN_L: reg_rdata_o = regs_q.blen[7:0];
                OFS_BLEN_H: reg_rdata_o = regs_q.blen[15:8];
                OFS_BCNT_L: reg_rdata_o = regs_q.bcnt[7:0];
                OFS_BCNT_H: reg_rdata_o = regs_q.bcnt[15:8];
                OFS_STAT1:  reg_rdata_o = {5'b0, regs_q.f_tmo, regs_q.f_done, 1'b0};
                OFS_STAT2:  reg_rdata_o = {2'b00, seq_hold, seq_active, 4'b0000};
                OFS_TMO_L:  reg_rdata_o = regs_q.tmo[7:0];
                OFS_TMO_H:  reg_rdata_o = regs_q.tmo[15:8];
                default:    reg_rdata_o = 8'h00;
            endcase
        end
    end

    assign done_flag       = regs_q.f_done;
    assign card_cmd_idx_o  = regs_q.idx;
    assign card_arg_o      = regs_q.arg;
    assign card_rsp_type_o = regs_q.rkind;
    assign card_cmd_type_o = regs_q.ctype;
    assign card_write_o    = regs_q.wdir;
    assign card_blk_len_o  = regs_q.blen[BLK_LEN_W-1:0];
    assign card_blk_cnt_o  = regs_q.bcnt;
endmodule

// File: rtl/sdc_cmd_regs_chk.sv
module sdc_cmd_regs_chk
    import sdc_pkg::*;
(
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   reg_wr_i,
    input logic [ADDR_W-1:0]      reg_addr_i,
    input logic [7:0]             reg_wdata_i,
    input logic                   card_req_o,
    input logic                   card_ack_i,
    input logic [7:0]             card_cmd_idx_o,
    input logic [7:0]             card_rsp_type_o,
    input logic                   card_rsp_valid_i,
    input logic [RSP_BYTES*8-1:0] card_rsp_i,
    input logic                   seq_active,
    input logic                   seq_pending,
    input logic                   seq_capture,
    input logic                   seq_done,
    input logic                   seq_tmo,
    input logic                   done_flag,
    input logic [RSP_BYTES*8-1:0] rsp_flat
);
    assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        card_req_o && !card_ack_i |=> card_req_o);

    assert_idx_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_active && reg_wr_i && reg_addr_i == OFS_IDX |=> $stable(card_cmd_idx_o));

    assert_last_byte_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_capture |=> rsp_flat[7:0] == $past(card_rsp_i[RSP_BYTES*8-1 -: 8]));

    assert_done_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_done |=> done_flag);

    assert_rsp_beats_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_tmo |-> !card_rsp_valid_i);

    assert_no_rsp_finishes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_pending && card_ack_i && card_rsp_type_o == RKIND_NONE |=> !seq_active);

    assert_flush_zeroes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_i && reg_addr_i == OFS_CTRL && reg_wdata_i[CTRL_FLUSH_BIT] && !seq_active
        |=> rsp_flat == '0);
endmodule

bind sdc_cmd_regs sdc_cmd_regs_chk u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .reg_wr_i         (reg_wr_i),
    .reg_addr_i       (reg_addr_i),
    .reg_wdata_i      (reg_wdata_i),
    .card_req_o       (card_req_o),
    .card_ack_i       (card_ack_i),
    .card_cmd_idx_o   (card_cmd_idx_o),
    .card_rsp_type_o  (card_rsp_type_o),
    .card_rsp_valid_i (card_rsp_valid_i),
    .card_rsp_i       (card_rsp_i),
    .seq_active       (seq_active),
    .seq_pending      (seq_pending),
    .seq_capture      (seq_capture),
    .seq_done         (seq_done),
    .seq_tmo          (seq_tmo),
    .done_flag        (done_flag),
    .rsp_flat         (rsp_flat)
);

// File: tb/sdc_cmd_regs_tb.sv
`timescale 1ns/1ps
module sdc_cmd_regs_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         card_req;
    logic         card_ack = 1'b0;
    logic [7:0]   card_idx;
    logic [31:0]  card_arg;
    logic [7:0]   card_rkind;
    logic [3:0]   card_ctype;
    logic         card_wdir;
    logic [10:0]  card_blen;
    logic [15:0]  card_bcnt;
    logic         card_rv = 1'b0;
    logic [127:0] card_rsp = '0;
    logic         card_busy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int         c_ack_dly = 0;
    int         c_rsp_dly = 2;
    int         c_busy_n = 0;
    bit         c_respond = 1;
    logic [127:0] c_rsp = '0;
    int         req_cnt = 0;
    logic [7:0] seen_idx = '0;
    logic [3:0] seen_ctype = '0;
    logic       seen_wdir = 1'b0;

    typedef struct {
        logic [5:0] a;
        logic [7:0] e;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    sdc_cmd_regs u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .card_req_o(card_req), .card_ack_i(card_ack),
        .card_cmd_idx_o(card_idx), .card_arg_o(card_arg), .card_rsp_type_o(card_rkind),
        .card_cmd_type_o(card_ctype), .card_write_o(card_wdir),
        .card_blk_len_o(card_blen), .card_blk_cnt_o(card_bcnt),
        .card_rsp_valid_i(card_rv), .card_rsp_i(card_rsp), .card_busy_i(card_busy)
    );

    // Monitor: pops expected read values and compares
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (reg_rdata !== it.e) begin
                n_fail++;
                $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h", it.tag, it.a, reg_rdata, it.e);
            end
        end
    end

    // Card-side model
    initial begin
        forever begin
            @(posedge clk); #1;
            if (card_req) begin
                for (int k = 0; k < c_ack_dly; k++) begin @(posedge clk); #1; end
                card_ack = 1'b1;
                req_cnt++;
                seen_idx = card_idx;
                seen_ctype = card_ctype;
                seen_wdir = card_wdir;
                @(posedge clk); #1;
                card_ack = 1'b0;
                if (c_respond && card_rkind != 8'd0) begin
                    for (int k = 0; k < c_rsp_dly; k++) begin @(posedge clk); #1; end
                    card_rv = 1'b1;
                    card_rsp = c_rsp;
                    card_busy = (c_busy_n > 0);
                    @(posedge clk); #1;
                    card_rv = 1'b0;
                    for (int k = 0; k < c_busy_n; k++) begin @(posedge clk); #1; end
                    card_busy = 1'b0;
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        sb_q.push_back('{a: a, e: e, tag: tag});
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    function automatic logic [127:0] pattern(input logic [7:0] base);
        logic [127:0] v;
        for (int n = 0; n < 16; n++) v[8*n +: 8] = base + 8'(n);
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        idle(200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 card_req after reset", card_req, 0);
        rd_exp(6'h00, 8'h00, "R1 control");
        rd_exp(6'h29, 8'h00, "R1 status1");
        rd_exp(6'h2A, 8'h00, "R1 status2");
        rd_exp(6'h10, 8'h00, "R1 rsp byte 0x10");
        rd_exp(6'h1F, 8'h00, "R1 rsp byte 0x1F");
        rd_exp(6'h2C, 8'hFF, "R1 timeout low");
        rd_exp(6'h2D, 8'h00, "R1 timeout high");

        // R2 register programming
        wr(6'h01, 8'h11);
        wr(6'h02, 8'h02);
        wr(6'h04, 8'h78); wr(6'h05, 8'h56); wr(6'h06, 8'h34); wr(6'h07, 8'h12);
        wr(6'h0C, 8'hFF); wr(6'h0D, 8'hA1);
        wr(6'h0E, 8'h03); wr(6'h0F, 8'h00);
        rd_exp(6'h01, 8'h11, "R2 index");
        rd_exp(6'h02, 8'h02, "R2 rsp kind");
        rd_exp(6'h05, 8'h56, "R2 arg byte1");
        rd_exp(6'h0D, 8'hA1, "R2 blen high with flags");
        rd_exp(6'h0E, 8'h03, "R2 bcnt low");
        chk("R2 card_arg_o", card_arg, 32'h12345678);
        chk("R2 card_blk_len_o", card_blen, 11'h1FF);
        chk("R2 card_blk_cnt_o", card_bcnt, 16'd3);

        // Command A: multi-block write tag, short response, late ack
        c_ack_dly = 4; c_rsp_dly = 20; c_busy_n = 0; c_respond = 1;
        c_rsp = pattern(8'hA0);
        wr(6'h00, 8'h35);
        rd_exp(6'h00, 8'h35, "R3 start bit pending before ack");
        wr(6'h01, 8'h77);
        wr(6'h00, 8'h01);
        rd_exp(6'h2A, 8'h10, "R6 cmd busy bit in flight");
        idle(60);
        chk("R4 single request launched", req_cnt, 1);
        chk("R3 card_cmd_type_o", seen_ctype, 4'd3);
        chk("R3 card_write_o", seen_wdir, 1'b1);
        chk("R3 card index", seen_idx, 8'h11);
        rd_exp(6'h01, 8'h11, "R4 index write dropped while busy");
        rd_exp(6'h00, 8'h34, "R3 start self-cleared, R4 ctrl write dropped");
        rd_exp(6'h29, 8'h02, "R6 done flag");
        rd_exp(6'h2A, 8'h00, "R6 busy cleared");
        for (int k = 0; k < 16; k++) begin
            rd_exp(6'h10 + 6'(k), 8'hA0 + 8'((k + 15) % 16), "R5 response byte placement");
        end
        wr(6'h29, 8'h00);
        rd_exp(6'h29, 8'h02, "R11 write 0 keeps flag");
        wr(6'h29, 8'h02);
        rd_exp(6'h29, 8'h00, "R11 write 1 clears done");

        // Command B: timeout at exact boundary
        wr(6'h2C, 8'd10); wr(6'h2D, 8'h00);
        c_ack_dly = 0; c_respond = 0;
        wr(6'h00, 8'h01);
        idle(10);
        rd_exp(6'h29, 8'h00, "R7 no timeout one cycle early");
        rd_exp(6'h29, 8'h04, "R7 timeout flag at limit");
        idle(5);
        rd_exp(6'h10, 8'hAF, "R7 buffer unchanged on timeout");
        rd_exp(6'h2A, 8'h00, "R7 idle after timeout");
        wr(6'h29, 8'h04);
        rd_exp(6'h29, 8'h00, "R11 write 1 clears timeout");

        // Command C: no response kind
        c_respond = 1; c_rsp = pattern(8'h30);
        wr(6'h02, 8'h00);
        wr(6'h00, 8'h01);
        idle(10);
        chk("R8 request launched", req_cnt, 3);
        rd_exp(6'h29, 8'h02, "R8 done without response");
        rd_exp(6'h11, 8'hA0, "R8 buffer unchanged");
        wr(6'h29, 8'h06);

        // Command D: response with busy phase
        c_rsp = pattern(8'h50); c_rsp_dly = 2; c_busy_n = 15;
        wr(6'h02, 8'h09);
        wr(6'h00, 8'h21);
        idle(8);
        rd_exp(6'h2A, 8'h30, "R9 data busy bit during busy phase");
        rd_exp(6'h29, 8'h00, "R9 done held off during busy");
        idle(40);
        rd_exp(6'h29, 8'h02, "R9 done after busy");
        rd_exp(6'h2A, 8'h00, "R9 busy bits cleared");
        rd_exp(6'h11, 8'h50, "R5 new response byte 0");
        rd_exp(6'h10, 8'h5F, "R5 new response byte 15");

        // R10 flush
        wr(6'h00, 8'h08);
        rd_exp(6'h00, 8'h00, "R10 flush bit reads 0");
        rd_exp(6'h10, 8'h00, "R10 byte 0x10 cleared");
        rd_exp(6'h11, 8'h00, "R10 byte 0x11 cleared");
        rd_exp(6'h1F, 8'h00, "R10 byte 0x1F cleared");
        rd_exp(6'h29, 8'h02, "R10 flush leaves flags");

        idle(4);
        finish_run();
    end
endmodule